// File: doc/BRIEF.md
# Configurable Stereo Audio Serial Transmitter

This block turns queued audio samples into a three-wire serial audio stream: a serial clock, a word-select line and a data line. Samples come in through a valid/ready write port that steers each word into a left or a right queue. The serial clock is divided down from the core clock by a programmable even ratio. Data and word-select change on the falling serial-clock edge, so a receiver samples on the rising edge.

Framing is chosen from a parallel configuration input. The options are standard I2S, left-justified or right-justified data, a sample width code, word-select polarity, mono duplication and a fixed 64-clock frame. Configuration is captured only while the transmitter is stopped. The enable input is synchronized before use. When enable drops, the sample in flight is completed. A clear input empties both queues while the transmitter is idle, and per-channel done flags report that the queues are empty.

Top module: `aud_i2s_tx`

## Requirements
- R1: `cfgMode` 0 and 3 select I2S framing, where word-select changes one serial clock before the slot's MSB. 1 selects left-justified framing, where the MSB is on the first clock of the slot. 2 selects right-justified framing, where the LSB is on the last clock of the slot and the earlier bits are 0. In both justified modes, bits after the LSB are 0.
- R2: `cfgWidth` codes 0..4 give 8, 16, 18, 24 and 32 data bits. Codes 5..7 send 16 bits. With `cfgFixed`=0, a slot (half frame) lasts 8 clocks for code 0, 16 clocks for code 1 and 32 clocks for every other code.
- R3: With `cfgFixed`=1, every slot lasts 32 serial clocks whatever the width.
- R4: In I2S framing, `cfgPol`=0 puts the left slot at word-select 0 and `cfgPol`=1 puts it at 1. In the justified framings the sense is reversed. The left slot is always sent first.
- R5: With `cfgMono`=1, each sample is taken from the left queue and sent in both the left and the right slot. The right queue is not read.
- R6: When enable drops, output stops after the current slot completes (stereo) or after the current frame completes (mono). The serial clock then stays at 0, with no partial slot.
- R7: With `cfgDma`=1, a stop empties both queues. With `cfgDma`=0, queued samples survive a stop and are sent after the next enable.
- R8: `cfgClear` empties both queues only while enable is low. `doneLeftO` and `doneRightO` go high once the flush is done and stay high until `cfgClear` drops. `wrReady` is 0 during a clear. A clear raised while running has no effect.
- R9: Changes to the mode, width, polarity, mono, fixed and DMA fields while running do not affect the stream until the next start.
- R10: A slot that begins with its queue empty carries all-zero data and sets the sticky `underrunO` flag. The flag is cleared by an honoured clear.
- R11: The serial-clock period is 2*(`divHalf`+1) core clocks. `sdO` and `wsO` never change on a rising serial-clock edge.
- R12: After reset `sckO`, `wsO`, `sdO`, `underrunO` and both done flags are 0, and `wrReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Run request (asynchronous, synchronized inside) |
| cfgClear | input | 1 | Queue flush request |
| cfgMode | input | 2 | Framing select |
| cfgWidth | input | 3 | Sample width code |
| cfgFixed | input | 1 | Force 32-clock slots |
| cfgPol | input | 1 | Word-select polarity |
| cfgMono | input | 1 | Duplicate left samples into both slots |
| cfgDma | input | 1 | Discard queued samples on stop |
| divHalf | input | 8 | Half serial-clock period minus one, in core clocks |
| wrValid | input | 1 | Write strobe for a sample |
| wrRight | input | 1 | 1 targets the right queue, 0 the left queue |
| wrData | input | 32 | Sample, right-aligned |
| wrReady | output | 1 | Write accepted when high |
| sckO | output | 1 | Serial clock |
| wsO | output | 1 | Word select |
| sdO | output | 1 | Serial data |
| doneLeftO | output | 1 | Left queue flushed |
| doneRightO | output | 1 | Right queue flushed |
| underrunO | output | 1 | Sticky empty-slot flag |

## Verification
The stream is captured on every rising serial-clock edge and decoded slot by slot against values computed from the requirements. It is run in I2S with mode codes 0 and 3, and in left- and right-justified framing. The widths used are 8, 16, 18 and 24 bits, with both polarities and with the fixed 64-clock frame. Together these runs separate the three alignments, the polarity inversion between framings and the two slot-length rules. Mono runs with a deliberately different right queue show whether the right data leak in. Paired runs that differ only in the DMA bit, or in a configuration change made while running, show whether queued samples are kept or dropped and whether fields are latched at the right time. Empty-queue runs and clears made while idle and while running cover zero fill, the sticky flag and the gating of the flush.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  localparam int POS_W = 6;

  typedef enum logic [1:0] {FRM_I2S, FRM_LEFT, FRM_RIGHT} frame_e;

  typedef struct packed {
    logic              tick;
    logic              slotStart;
    logic              rightSlot;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  halfLen;
    logic [POS_W-1:0]  sampleBits;
    frame_e            frame;
    logic              mono;
    logic              stopFlush;
    logic              clearGo;
    logic              active;
  } laneCtl_t;

  function automatic logic [POS_W-1:0] widthOf(input logic [2:0] code);
    case (code)
      3'd0:    return POS_W'(8);
      3'd2:    return POS_W'(18);
      3'd3:    return POS_W'(24);
      3'd4:    return POS_W'(32);
      default: return POS_W'(16);
    endcase
  endfunction

  function automatic logic [POS_W-1:0] halfOf(input logic [2:0] code, input logic fixed);
    if (fixed) return POS_W'(32);
    case (code)
      3'd0:    return POS_W'(8);
      3'd1:    return POS_W'(16);
      default: return POS_W'(32);
    endcase
  endfunction

  function automatic frame_e frameOf(input logic [1:0] code);
    case (code)
      2'd1:    return FRM_LEFT;
      2'd2:    return FRM_RIGHT;
      default: return FRM_I2S;
    endcase
  endfunction
endpackage

// File: rtl/audtx_fifo.sv
module audtx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rdPtr, wrPtr;
  logic [CW-1:0]     count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push && !full) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgClear,
  input  logic [1:0]       cfgMode,
  input  logic [2:0]       cfgWidth,
  input  logic             cfgFixed,
  input  logic             cfgPol,
  input  logic             cfgMono,
  input  logic             cfgDma,
  input  logic [DIV_W-1:0] divHalf,
  output logic             sckO,
  output logic             wsO,
  output laneCtl_t         ctl
);
  logic [1:0]       enPipe;
  logic             enSync;
  logic             running, sckQ, rightQ, wsQ;
  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] posQ, halfQ, bitsQ, nextPos;
  logic             nextRight, polQ, monoQ, dmaQ;
  frame_e           frameQ;
  logic             wrap, startNow, fallNow, atEnd, stopNow, tickNow;
  logic             wsChan, leftLevel;

  assign enSync = enPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN) enPipe <= '0;
    else       enPipe <= {enPipe[0], cfgEnable};
  end

  // configuration is captured only while stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= FRM_I2S;
      bitsQ  <= POS_W'(16);
      halfQ  <= POS_W'(16);
      polQ   <= 1'b0;
      monoQ  <= 1'b0;
      dmaQ   <= 1'b0;
    end else if (!running) begin
      frameQ <= frameOf(cfgMode);
      bitsQ  <= widthOf(cfgWidth);
      halfQ  <= halfOf(cfgWidth, cfgFixed);
      polQ   <= cfgPol;
      monoQ  <= cfgMono;
      dmaQ   <= cfgDma;
    end
  end

  assign wrap     = (divCnt == divHalf);
  assign startNow = !running && enSync;
  assign fallNow  = running && sckQ && wrap;
  assign atEnd    = (posQ == halfQ - 1'b1);
  assign stopNow  = fallNow && !enSync && atEnd && (!monoQ || rightQ);
  assign tickNow  = startNow || (fallNow && !stopNow);

  always_comb begin
    if (startNow) begin
      nextPos   = '0;
      nextRight = 1'b0;
    end else if (atEnd) begin
      nextPos   = '0;
      nextRight = !rightQ;
    end else begin
      nextPos   = posQ + 1'b1;
      nextRight = rightQ;
    end
  end

  // I2S word select leads the data by one serial clock
  assign wsChan    = (frameQ == FRM_I2S && nextPos == halfQ - 1'b1) ? !nextRight : nextRight;
  assign leftLevel = (frameQ == FRM_I2S) ? polQ : !polQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      sckQ    <= 1'b0;
      divCnt  <= '0;
      posQ    <= '0;
      rightQ  <= 1'b0;
      wsQ     <= 1'b0;
    end else begin
      if (startNow) begin
        running <= 1'b1;
        sckQ    <= 1'b0;
        divCnt  <= '0;
      end else if (running) begin
        if (wrap) begin
          divCnt <= '0;
          sckQ   <= !sckQ;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        if (stopNow) running <= 1'b0;
      end
      if (tickNow) begin
        posQ   <= nextPos;
        rightQ <= nextRight;
        wsQ    <= wsChan ? !leftLevel : leftLevel;
      end
    end
  end

  assign sckO = sckQ;
  assign wsO  = wsQ;

  always_comb begin
    ctl            = '0;
    ctl.tick       = tickNow;
    ctl.slotStart  = tickNow && (nextPos == '0);
    ctl.rightSlot  = nextRight;
    ctl.pos        = nextPos;
    ctl.halfLen    = halfQ;
    ctl.sampleBits = bitsQ;
    ctl.frame      = frameQ;
    ctl.mono       = monoQ;
    ctl.stopFlush  = stopNow && dmaQ;
    ctl.clearGo    = cfgClear && !running && !enSync;
    ctl.active     = running;
  end

  a_r2_pos_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (posQ < halfQ));

  a_r6_stop_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(posQ) == $past(halfQ) - 1'b1));

  a_r6_idle_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> !sckQ);
endmodule

// File: rtl/audtx_lane.sv
module audtx_lane
  import audtx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic              wrValid,
  input  logic              wrRight,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              sdO,
  output logic              underrunO,
  output logic              doneLeftO,
  output logic              doneRightO
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] head [2];
  logic [1:0]        emptyV, fullV, pushV, popV;
  logic              flush;
  logic [DATA_W-1:0] curSample, selSample, loadSample;
  logic              slotEmpty, nextBit, sdQ, underrunQ, doneQ;
  logic [POS_W-1:0]  idxFull;

  assign flush   = ctl.stopFlush || ctl.clearGo;
  assign wrReady = !ctl.clearGo && !fullV[wrRight];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign pushV[ch] = wrValid && wrReady && (wrRight == ch[0]);
    audtx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .flush (flush),
      .push  (pushV[ch]),
      .din   (wrData),
      .pop   (popV[ch]),
      .dout  (head[ch]),
      .empty (emptyV[ch]),
      .full  (fullV[ch])
    );
  end

  always_comb begin
    loadSample = curSample;
    slotEmpty  = 1'b0;
    if (!ctl.rightSlot) begin
      loadSample = emptyV[0] ? '0 : head[0];
      slotEmpty  = emptyV[0];
    end else if (!ctl.mono) begin
      loadSample = emptyV[1] ? '0 : head[1];
      slotEmpty  = emptyV[1];
    end
  end

  assign popV[0]   = ctl.slotStart && !ctl.rightSlot && !emptyV[0];
  assign popV[1]   = ctl.slotStart && ctl.rightSlot && !ctl.mono && !emptyV[1];
  assign selSample = ctl.slotStart ? loadSample : curSample;

  always_comb begin
    nextBit = 1'b0;
    idxFull = '0;
    if (ctl.frame == FRM_RIGHT) begin
      idxFull = ctl.halfLen - 1'b1 - ctl.pos;
      if (ctl.pos >= ctl.halfLen - ctl.sampleBits) nextBit = selSample[idxFull[IDX_W-1:0]];
    end else begin
      idxFull = ctl.sampleBits - 1'b1 - ctl.pos;
      if (ctl.pos < ctl.sampleBits) nextBit = selSample[idxFull[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSample <= '0;
      sdQ       <= 1'b0;
      underrunQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      if (ctl.slotStart) curSample <= loadSample;
      if (ctl.tick)         sdQ <= nextBit;
      else if (!ctl.active) sdQ <= 1'b0;
      if (ctl.clearGo)                       underrunQ <= 1'b0;
      else if (ctl.slotStart && slotEmpty)   underrunQ <= 1'b1;
      doneQ <= ctl.clearGo;
    end
  end

  assign sdO        = sdQ;
  assign underrunO  = underrunQ;
  assign doneLeftO  = doneQ;
  assign doneRightO = doneQ;

  a_r8_left_done_empty: assert property (@(posedge clk) disable iff (!rstN)
    doneLeftO |-> emptyV[0]);

  a_r8_right_done_empty: assert property (@(posedge clk) disable iff (!rstN)
    doneRightO |-> emptyV[1]);

  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrunQ && !ctl.clearGo) |=> underrunQ);

  a_r5_mono_right_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slotStart && ctl.rightSlot && ctl.mono) |=> $stable(curSample));
endmodule

// File: rtl/aud_i2s_tx.sv
module aud_i2s_tx
  import audtx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgClear,
  input  logic [1:0]        cfgMode,
  input  logic [2:0]        cfgWidth,
  input  logic              cfgFixed,
  input  logic              cfgPol,
  input  logic              cfgMono,
  input  logic              cfgDma,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              wrValid,
  input  logic              wrRight,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              sckO,
  output logic              wsO,
  output logic              sdO,
  output logic              doneLeftO,
  output logic              doneRightO,
  output logic              underrunO
);
  laneCtl_t ctl;

  audtx_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgEnable (cfgEnable),
    .cfgClear  (cfgClear),
    .cfgMode   (cfgMode),
    .cfgWidth  (cfgWidth),
    .cfgFixed  (cfgFixed),
    .cfgPol    (cfgPol),
    .cfgMono   (cfgMono),
    .cfgDma    (cfgDma),
    .divHalf   (divHalf),
    .sckO      (sckO),
    .wsO       (wsO),
    .ctl       (ctl)
  );

  audtx_lane #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) i_lane (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrValid    (wrValid),
    .wrRight    (wrRight),
    .wrData     (wrData),
    .wrReady    (wrReady),
    .sdO        (sdO),
    .underrunO  (underrunO),
    .doneLeftO  (doneLeftO),
    .doneRightO (doneRightO)
  );

  a_r11_data_steady_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sckO) |-> ($stable(sdO) && $stable(wsO)));
endmodule

// File: tb/test_aud_i2s_tx.sv
module test_aud_i2s_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgClear = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [2:0]  cfgWidth = 3'd1;
  logic        cfgFixed = 1'b0, cfgPol = 1'b0, cfgMono = 1'b0, cfgDma = 1'b0;
  logic [7:0]  divHalf = 8'd1;
  logic        wrValid = 1'b0, wrRight = 1'b0;
  logic [31:0] wrData = '0;
  logic        wrReady, sckO, wsO, sdO, doneLeftO, doneRightO, underrunO;

  int compared = 0;
  int mismatched = 0;
  int nRec = 0;
  logic wsLog [512];
  logic sdLog [512];
  logic [31:0] expSmp [4];

  always #5 clk = ~clk;

  aud_i2s_tx i_aud_i2s_tx (.*);

  always @(posedge sckO) begin
    if (nRec < 512) begin
      wsLog[nRec] = wsO;
      sdLog[nRec] = sdO;
    end
    nRec = nRec + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd2: return 18;
      3'd3: return 24;
      3'd4: return 32;
      default: return 16;
    endcase
  endfunction

  function automatic int halfOf(input logic [2:0] c, input logic fx);
    if (fx) return 32;
    if (c == 3'd0) return 8;
    if (c == 3'd1) return 16;
    return 32;
  endfunction

  function automatic logic expSd(input logic [31:0] s, input int p, input int h, input int b, input logic [1:0] m);
    if (m == 2'd2) return (p >= h - b) ? s[h-1-p] : 1'b0;
    return (p < b) ? s[b-1-p] : 1'b0;
  endfunction

  function automatic logic expWs(input bit isRight, input int p, input int h, input logic [1:0] m, input logic pol);
    bit i2s = (m == 2'd0 || m == 2'd3);
    logic leftLvl = i2s ? pol : !pol;
    bit chan = isRight ^ (i2s && p == h - 1);
    return chan ? !leftLvl : leftLvl;
  endfunction

  // checks recorded slots against expSmp using the given configuration
  task automatic checkStream(input string tag, input int nSlots, input logic [1:0] m,
                             input logic [2:0] wc, input logic fx, input logic pol);
    int h = halfOf(wc, fx);
    int b = bitsOf(wc);
    check(nRec == nSlots * h, {tag, " bit count"}, nRec, nSlots * h);
    for (int k = 0; k < nSlots; k++) begin
      int bad = 0;
      for (int p = 0; p < h; p++) begin
        int i = k * h + p;
        if (sdLog[i] !== expSd(expSmp[k], p, h, b, m)) bad++;
        if (wsLog[i] !== expWs(k % 2 == 1, p, h, m, pol)) bad++;
      end
      check(bad == 0, $sformatf("%s slot %0d", tag, k), bad, 0);
    end
  endtask

  task automatic pushSample(input logic right, input logic [31:0] d);
    while (!wrReady) @(negedge clk);
    wrRight = right;
    wrData  = d;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic runSlots(input int nSlots, input int h);
    nRec = 0;
    cfgEnable = 1'b1;
    while (nRec < (nSlots - 1) * h + 1) @(negedge clk);
    cfgEnable = 1'b0;
    repeat (8 * h + 40) @(negedge clk);
  endtask

  task automatic clearFifos();
    cfgClear = 1'b1;
    repeat (5) @(negedge clk);
    cfgClear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [2:0] wc, input logic fx,
                        input logic pol, input logic mono, input logic dma);
    cfgMode = m; cfgWidth = wc; cfgFixed = fx; cfgPol = pol; cfgMono = mono; cfgDma = dma;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    check(sckO == 1'b0 && wsO == 1'b0 && sdO == 1'b0, "R12 serial lines idle", {sckO, wsO, sdO}, 0);
    check(!underrunO && !doneLeftO && !doneRightO, "R12 flags low", {underrunO, doneLeftO, doneRightO}, 0);
    check(wrReady == 1'b1, "R12 ready", wrReady, 1);
  endtask

  task automatic testI2sStereo();
    clearFifos();
    setCfg(2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    expSmp = '{32'h0000_A5C3, 32'h0000_1234, 32'h0000_8001, 32'h0000_7FFE};
    for (int k = 0; k < 4; k++) pushSample(k[0], expSmp[k]);
    runSlots(4, 16);
    checkStream("R1 R4 R6 i2s16 stereo", 4, 2'd0, 3'd1, 1'b0, 1'b0);
    check(sckO == 1'b0, "R6 clock parked low", sckO, 0);
  endtask

  task automatic testLeftJust();
    clearFifos();
    setCfg(2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    expSmp = '{32'h00C3_5A71, 32'h0081_0F02, 0, 0};
    pushSample(1'b0, expSmp[0]);
    pushSample(1'b1, expSmp[1]);
    runSlots(2, 32);
    checkStream("R1 R2 R4 left-justified 24", 2, 2'd1, 3'd3, 1'b0, 1'b1);
  endtask

  task automatic testRightJust();
    clearFifos();
    setCfg(2'd2, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    expSmp = '{32'h0002_B3C5, 32'h0001_4D3A, 0, 0};
    pushSample(1'b0, expSmp[0]);
    pushSample(1'b1, expSmp[1]);
    runSlots(2, 32);
    checkStream("R1 R2 right-justified 18", 2, 2'd2, 3'd2, 1'b0, 1'b0);
  endtask

  task automatic testMode3Narrow();
    clearFifos();
    setCfg(2'd3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    expSmp = '{32'h0000_00B6, 32'h0000_0049, 0, 0};
    pushSample(1'b0, expSmp[0]);
    pushSample(1'b1, expSmp[1]);
    runSlots(2, 8);
    checkStream("R1 R2 R4 mode3 8-bit", 2, 2'd3, 3'd0, 1'b0, 1'b1);
  endtask

  task automatic testFixed();
    clearFifos();
    setCfg(2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    expSmp = '{32'h0000_00D2, 32'h0000_002D, 0, 0};
    pushSample(1'b0, expSmp[0]);
    pushSample(1'b1, expSmp[1]);
    runSlots(2, 32);
    checkStream("R3 fixed frame 8-bit", 2, 2'd0, 3'd0, 1'b1, 1'b0);
  endtask

  task automatic testReserved();
    clearFifos();
    setCfg(2'd1, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    expSmp = '{32'h0003_C3A5, 32'h0000_5A5A, 0, 0};
    pushSample(1'b0, expSmp[0]);
    pushSample(1'b1, expSmp[1]);
    runSlots(2, 32);
    checkStream("R2 reserved width code", 2, 2'd1, 3'd6, 1'b0, 1'b0);
  endtask

  task automatic testMono();
    clearFifos();
    setCfg(2'd1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    pushSample(1'b0, 32'h0000_C0DE);
    pushSample(1'b1, 32'h0000_FFFF);
    expSmp = '{32'h0000_C0DE, 32'h0000_C0DE, 0, 0};
    runSlots(1, 16);
    checkStream("R5 R6 mono duplicate", 2, 2'd1, 3'd1, 1'b0, 1'b1);
  endtask

  task automatic testKeepAndLatch();
    clearFifos();
    setCfg(2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    pushSample(1'b0, 32'h0000_1111);
    pushSample(1'b1, 32'h0000_2222);
    pushSample(1'b0, 32'h0000_3C3C);
    pushSample(1'b1, 32'h0000_4B4B);
    nRec = 0;
    cfgEnable = 1'b1;
    while (nRec < 1) @(negedge clk);
    cfgMode = 2'd2; cfgWidth = 3'd4; cfgPol = 1'b1;
    while (nRec < 17) @(negedge clk);
    cfgEnable = 1'b0;
    repeat (4) @(negedge clk);
    cfgMode = 2'd0; cfgWidth = 3'd1; cfgPol = 1'b0;
    repeat (200) @(negedge clk);
    expSmp = '{32'h0000_1111, 32'h0000_2222, 0, 0};
    checkStream("R9 config held while running", 2, 2'd0, 3'd1, 1'b0, 1'b0);
    runSlots(2, 16);
    expSmp = '{32'h0000_3C3C, 32'h0000_4B4B, 0, 0};
    checkStream("R7 register mode keeps queue", 2, 2'd0, 3'd1, 1'b0, 1'b0);
    check(underrunO == 1'b0, "R7 no underrun in register mode", underrunO, 0);
  endtask

  task automatic testDmaDiscard();
    clearFifos();
    setCfg(2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    pushSample(1'b0, 32'h0000_5151);
    pushSample(1'b1, 32'h0000_6262);
    pushSample(1'b0, 32'h0000_7373);
    pushSample(1'b1, 32'h0000_8484);
    runSlots(2, 16);
    expSmp = '{32'h0000_5151, 32'h0000_6262, 0, 0};
    checkStream("R7 dma first run", 2, 2'd0, 3'd1, 1'b0, 1'b0);
    runSlots(2, 16);
    expSmp = '{0, 0, 0, 0};
    checkStream("R7 R10 dma discard zeros", 2, 2'd0, 3'd1, 1'b0, 1'b0);
    check(underrunO == 1'b1, "R10 underrun after discard", underrunO, 1);
  endtask

  task automatic testClear();
    setCfg(2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    pushSample(1'b0, 32'h0000_9999);
    pushSample(1'b1, 32'h0000_AAAA);
    cfgClear = 1'b1;
    repeat (4) @(negedge clk);
    check(doneLeftO && doneRightO, "R8 done flags during clear", {doneLeftO, doneRightO}, 2'b11);
    check(wrReady == 1'b0, "R8 writes refused during clear", wrReady, 0);
    check(underrunO == 1'b0, "R10 clear resets underrun", underrunO, 0);
    cfgClear = 1'b0;
    repeat (3) @(negedge clk);
    check(!doneLeftO && !doneRightO, "R8 done flags drop", {doneLeftO, doneRightO}, 0);
    runSlots(2, 16);
    expSmp = '{0, 0, 0, 0};
    checkStream("R8 R10 flushed queues send zeros", 2, 2'd0, 3'd1, 1'b0, 1'b0);
    check(underrunO == 1'b1, "R10 sticky underrun", underrunO, 1);
    // clear while running is ignored
    clearFifos();
    pushSample(1'b0, 32'h0000_0F0F);
    pushSample(1'b1, 32'h0000_F0F0);
    pushSample(1'b0, 32'h0000_3333);
    pushSample(1'b1, 32'h0000_4444);
    nRec = 0;
    cfgEnable = 1'b1;
    while (nRec < 2) @(negedge clk);
    cfgClear = 1'b1;
    repeat (6) @(negedge clk);
    check(!doneLeftO && !doneRightO, "R8 clear ignored while running", {doneLeftO, doneRightO}, 0);
    cfgClear = 1'b0;
    while (nRec < 49) @(negedge clk);
    cfgEnable = 1'b0;
    repeat (200) @(negedge clk);
    expSmp = '{32'h0000_0F0F, 32'h0000_F0F0, 32'h0000_3333, 32'h0000_4444};
    checkStream("R8 queue intact after ignored clear", 4, 2'd0, 3'd1, 1'b0, 1'b0);
  endtask

  task automatic measurePeriod(input logic [7:0] d);
    realtime t0, t1;
    divHalf = d;
    clearFifos();
    cfgEnable = 1'b1;
    @(posedge sckO);
    t0 = $realtime;
    @(posedge sckO);
    t1 = $realtime;
    cfgEnable = 1'b0;
    repeat (400) @(negedge clk);
    check((t1 - t0) == 10.0 * 2 * (d + 1), $sformatf("R11 period div %0d", d),
          longint'(t1 - t0), 20 * (d + 1));
    divHalf = 8'd1;
  endtask

  initial begin
    #1_800_000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testI2sStereo();
    testLeftJust();
    testRightJust();
    testMode3Narrow();
    testFixed();
    testReserved();
    testMono();
    testKeepAndLatch();
    testDmaDiscard();
    testClear();
    measurePeriod(8'd1);
    measurePeriod(8'd3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule